// File: doc/BRIEF.md
# Multi-Cycle Floating-Point Adder/Subtractor

This unit adds or subtracts two floating-point words. Each word has a sign bit, a biased exponent and a fraction mantissa whose value is 0.1xxx in binary, so a nonzero operand has its top mantissa bit set. The all-zero word represents zero. A one-cycle start pulse loads both operands and the add/subtract select. A control state machine then walks the operation through a fixed set of steps. First it compares the exponents. Next it either passes the dominant operand through or right-aligns the smaller one and combines the mantissas in sign-magnitude form. Last it renormalizes one bit position per cycle, adjusting the exponent for each shift. A one-cycle done pulse marks the result, which the result port then holds until the next operation completes.

There are five comparison outcomes. The exponents can be equal. X can be larger by less than the mantissa width, or by at least that width. Y can be larger by less than the mantissa width, or by at least that width. When the gap reaches the mantissa width, the larger operand is copied and the mantissa combine step is skipped. Bits shifted out during alignment are dropped. There is no rounding, and infinities, NaNs and denormals are not modelled. The only flag is a sticky exponent overflow.

Top module: `fpas_unit`

## Requirements
- R1: After reset, `done` is 0, `ovf` is 0 and `result` is all zero.
- R2: With equal exponents the two mantissas are combined without shifting, and the shared exponent is the starting exponent for normalization.
- R3: When one exponent exceeds the other by a gap smaller than MAN_W, the mantissa of the smaller operand is shifted right by the gap, dropping the low bits, before the combine. This works in either direction.
- R4: When the gap is MAN_W or more, the word with the larger exponent, including its effective sign, is the result unchanged. `done` rises 2 cycles after the start edge.
- R5: With `sub`=1 the sign of Y is inverted before any other step, so the result is X minus Y.
- R6: When the effective signs differ, the smaller aligned mantissa is subtracted from the larger one and the result takes the sign of the larger. On equal mantissas X is treated as the larger.
- R7: A combined mantissa of zero yields the all-zero result word (positive sign, zero exponent, zero mantissa) with `done` 2 cycles after the start edge.
- R8: Normalization takes one step per cycle. A carry above the top mantissa bit shifts the mantissa right by one and increments the exponent. A clear top bit shifts it left by one and decrements the exponent. `done` rises 3+S cycles after the start edge, where S is the number of shifts.
- R9: A right normalization step with the exponent at its maximum leaves the exponent at the maximum and sets `ovf`, which stays 1 until reset.
- R10: `done` is high for exactly one cycle per operation. A `start` that arrives while an operation is in progress is ignored.
- R11: Left normalization stops once the exponent reaches zero, even if the top mantissa bit is still clear.
- R12: Word layout: bit 24 is the sign (1 = negative), bits 23:16 are the exponent, and bits 15:0 are the mantissa, with bit 15 weighted 1/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an operation when the unit is idle |
| sub | input | 1 | 1 selects X minus Y, 0 selects X plus Y |
| x_in | input | 25 | Operand X, sign/exponent/mantissa |
| y_in | input | 25 | Operand Y, sign/exponent/mantissa |
| result | output | 25 | Last completed result, held between operations |
| done | output | 1 | One-cycle pulse when `result` is updated |
| ovf | output | 1 | Sticky exponent overflow flag |

## Verification
Take the rising edge that samples `start` as edge 0. `done` and the new `result` are due after edge 2 on the pass-through and zero paths, and after edge 3+S when S normalization shifts are needed. The bench's reference model works out S and the expected word from the operands alone. It then checks `done` at every negative clock edge: the pulse must appear exactly in the predicted cycle, and `done` must be low in every cycle before it and in the cycle after it. `result` and `ovf` are compared in the predicted cycle. One run drives a second `start` while the unit is busy and expects the first operation's timing and value to be unaffected.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMP  = 3'd1,
    ST_ADD  = 3'd2,
    ST_NORM = 3'd3,
    ST_DONE = 3'd4
  } fpas_state_e;
endpackage

// File: rtl/fpas_align.sv
module fpas_align #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic             xs,
  input  logic [EXP_W-1:0] xe,
  input  logic [MAN_W-1:0] xm,
  input  logic             ys,
  input  logic [EXP_W-1:0] ye,
  input  logic [MAN_W-1:0] ym,
  output logic             bypass,
  output logic             big_s,
  output logic [EXP_W-1:0] big_e,
  output logic [MAN_W-1:0] big_m,
  output logic             small_s,
  output logic [MAN_W-1:0] small_m
);
  localparam logic [EXP_W:0] GAP_LIMIT = (EXP_W+1)'(MAN_W);

  function automatic logic [EXP_W-1:0] exp_gap(input logic [EXP_W-1:0] a,
                                               input logic [EXP_W-1:0] b);
    return a - b;
  endfunction

  logic             x_dom;
  logic [EXP_W-1:0] gap;
  logic [MAN_W-1:0] raw_small;

  always_comb begin
    x_dom     = (xe >= ye);
    gap       = x_dom ? exp_gap(xe, ye) : exp_gap(ye, xe);
    bypass    = ({1'b0, gap} >= GAP_LIMIT);
    big_s     = x_dom ? xs : ys;
    big_e     = x_dom ? xe : ye;
    big_m     = x_dom ? xm : ym;
    small_s   = x_dom ? ys : xs;
    raw_small = x_dom ? ym : xm;
    small_m   = bypass ? '0 : (raw_small >> gap);
  end
endmodule

// File: rtl/fpas_mant_alu.sv
module fpas_mant_alu #(
  parameter int MAN_W = 16
) (
  input  logic             big_s,
  input  logic [MAN_W-1:0] big_m,
  input  logic             small_s,
  input  logic [MAN_W-1:0] small_m,
  output logic [MAN_W:0]   sum_m,
  output logic             sum_s,
  output logic             sum_zero
);
  function automatic logic [MAN_W:0] mag_add(input logic [MAN_W-1:0] a,
                                             input logic [MAN_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [MAN_W:0] mag_sub(input logic [MAN_W-1:0] a,
                                             input logic [MAN_W-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  always_comb begin
    if (big_s == small_s) begin
      sum_m = mag_add(big_m, small_m);
      sum_s = big_s;
    end else if (big_m >= small_m) begin
      sum_m = mag_sub(big_m, small_m);
      sum_s = big_s;
    end else begin
      sum_m = mag_sub(small_m, big_m);
      sum_s = small_s;
    end
    sum_zero = (sum_m == '0);
  end
endmodule

// File: rtl/fpas_norm_step.sv
module fpas_norm_step #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic [MAN_W:0]   m_cur,
  input  logic [EXP_W-1:0] e_cur,
  output logic [MAN_W:0]   m_next,
  output logic [EXP_W-1:0] e_next,
  output logic             step_r,
  output logic             step_l,
  output logic             exp_ovf,
  output logic             settled
);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  always_comb begin
    step_r  = m_cur[MAN_W];
    step_l  = !m_cur[MAN_W] && !m_cur[MAN_W-1] && (e_cur != '0);
    settled = !step_r && !step_l;
    exp_ovf = step_r && (e_cur == EXP_MAX);
    m_next  = m_cur;
    e_next  = e_cur;
    if (step_r) begin
      m_next = m_cur >> 1;
      e_next = exp_ovf ? e_cur : e_cur + 1'b1;
    end else if (step_l) begin
      m_next = m_cur << 1;
      e_next = e_cur - 1'b1;
    end
  end
endmodule

// File: rtl/fpas_unit.sv
module fpas_unit #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sub,
  input  logic [WORD_W-1:0] x_in,
  input  logic [WORD_W-1:0] y_in,
  output logic [WORD_W-1:0] result,
  output logic              done,
  output logic              ovf
);
  import fpas_pkg::*;

  fpas_state_e st_q;

  logic             xs_q, ys_q;
  logic [EXP_W-1:0] xe_q, ye_q;
  logic [MAN_W-1:0] xm_q, ym_q;

  logic             al_bs_q, al_ss_q;
  logic [EXP_W-1:0] al_be_q;
  logic [MAN_W-1:0] al_bm_q, al_sm_q;

  logic             acc_s_q;
  logic [EXP_W-1:0] acc_e_q;
  logic [MAN_W:0]   acc_m_q;

  logic [WORD_W-1:0] res_q;
  logic              ovf_q;

  // named internal events
  logic             bypass_take;
  logic             nrm_right, nrm_left, nrm_ovf, nrm_settled;
  logic             busy;

  logic             a_bypass, a_bs, a_ss;
  logic [EXP_W-1:0] a_be;
  logic [MAN_W-1:0] a_bm, a_sm;

  logic [MAN_W:0]   s_m;
  logic             s_s, s_zero;

  logic [MAN_W:0]   n_m;
  logic [EXP_W-1:0] n_e;

  fpas_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .xs(xs_q), .xe(xe_q), .xm(xm_q),
    .ys(ys_q), .ye(ye_q), .ym(ym_q),
    .bypass(a_bypass), .big_s(a_bs), .big_e(a_be), .big_m(a_bm),
    .small_s(a_ss), .small_m(a_sm)
  );

  fpas_mant_alu #(.MAN_W(MAN_W)) u_alu (
    .big_s(al_bs_q), .big_m(al_bm_q),
    .small_s(al_ss_q), .small_m(al_sm_q),
    .sum_m(s_m), .sum_s(s_s), .sum_zero(s_zero)
  );

  fpas_norm_step #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .m_cur(acc_m_q), .e_cur(acc_e_q),
    .m_next(n_m), .e_next(n_e),
    .step_r(nrm_right), .step_l(nrm_left),
    .exp_ovf(nrm_ovf), .settled(nrm_settled)
  );

  assign bypass_take = (st_q == ST_CMP) && a_bypass;
  assign busy        = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      xs_q    <= 1'b0;
      xe_q    <= '0;
      xm_q    <= '0;
      ys_q    <= 1'b0;
      ye_q    <= '0;
      ym_q    <= '0;
      al_bs_q <= 1'b0;
      al_ss_q <= 1'b0;
      al_be_q <= '0;
      al_bm_q <= '0;
      al_sm_q <= '0;
      acc_s_q <= 1'b0;
      acc_e_q <= '0;
      acc_m_q <= '0;
      res_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            xs_q <= x_in[WORD_W-1];
            xe_q <= x_in[MAN_W +: EXP_W];
            xm_q <= x_in[MAN_W-1:0];
            ys_q <= y_in[WORD_W-1] ^ sub;
            ye_q <= y_in[MAN_W +: EXP_W];
            ym_q <= y_in[MAN_W-1:0];
            st_q <= ST_CMP;
          end
        end
        ST_CMP: begin
          if (a_bypass) begin
            acc_s_q <= a_bs;
            acc_e_q <= a_be;
            acc_m_q <= {1'b0, a_bm};
            st_q    <= ST_NORM;
          end else begin
            al_bs_q <= a_bs;
            al_be_q <= a_be;
            al_bm_q <= a_bm;
            al_ss_q <= a_ss;
            al_sm_q <= a_sm;
            st_q    <= ST_ADD;
          end
        end
        ST_ADD: begin
          if (s_zero) begin
            res_q <= '0;
            st_q  <= ST_DONE;
          end else begin
            acc_s_q <= s_s;
            acc_e_q <= al_be_q;
            acc_m_q <= s_m;
            st_q    <= ST_NORM;
          end
        end
        ST_NORM: begin
          if (nrm_settled) begin
            res_q <= {acc_s_q, acc_e_q, acc_m_q[MAN_W-1:0]};
            st_q  <= ST_DONE;
          end else begin
            acc_m_q <= n_m;
            acc_e_q <= n_e;
            if (nrm_ovf) ovf_q <= 1'b1;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign result = res_q;
  assign done   = (st_q == ST_DONE);
  assign ovf    = ovf_q;
endmodule

// File: rtl/fpas_unit_chk.sv
module fpas_unit_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              ovf,
  input logic [WORD_W-1:0] result,
  input logic              bypass_take,
  input logic              nrm_right,
  input logic              nrm_left,
  input logic              nrm_ovf,
  input logic              busy,
  input logic [EXP_W-1:0]  acc_e
);
  logic [EXP_W-1:0] res_e;
  logic [MAN_W-1:0] res_m;
  assign res_e = result[MAN_W +: EXP_W];
  assign res_m = result[MAN_W-1:0];

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);  // R9
  AST_ZERO_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_m == '0) |-> (res_e == '0 && !result[WORD_W-1]));  // R7
  AST_DONE_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_m != '0 && res_e != '0) |-> res_m[MAN_W-1]);  // R8
  AST_RSHIFT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (nrm_right && !nrm_ovf) |=> (acc_e == EXP_W'($past(acc_e) + 1'b1)));  // R8
  AST_LSHIFT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    nrm_left |=> (acc_e == EXP_W'($past(acc_e) - 1'b1)));  // R8
  AST_OVF_KEEPS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    nrm_ovf |=> (ovf && $stable(acc_e)));  // R9
  AST_BYPASS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_take |=> (busy && !done));  // R4
endmodule

bind fpas_unit fpas_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .ovf(ovf), .result(result),
  .bypass_take(bypass_take), .nrm_right(nrm_right), .nrm_left(nrm_left),
  .nrm_ovf(nrm_ovf), .busy(busy), .acc_e(acc_e_q)
);

// File: tb/tb_fpas_unit.sv
`timescale 1ns/1ps
module tb_fpas_unit;
  localparam int EXP_W = 8;
  localparam int MAN_W = 16;
  localparam int WORD_W = 1 + EXP_W + MAN_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sub = 1'b0;
  logic [WORD_W-1:0] x_in = '0;
  logic [WORD_W-1:0] y_in = '0;
  logic [WORD_W-1:0] result;
  logic done, ovf;

  int checks = 0;
  int errors = 0;
  bit exp_ovf = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fpas_unit #(.EXP_W(EXP_W), .MAN_W(MAN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sub(sub),
    .x_in(x_in), .y_in(y_in), .result(result), .done(done), .ovf(ovf)
  );

  function automatic logic [WORD_W-1:0] mk(input bit s, input int e, input int m);
    return {s, EXP_W'(e), MAN_W'(m)};
  endfunction

  task automatic check(input string tag, input bit ok, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: value and cycle of done after start edge
  task automatic ref_op(input logic [WORD_W-1:0] x, input logic [WORD_W-1:0] y,
                        input bit sb, output logic [WORD_W-1:0] r, output int lat,
                        output bit ov);
    int ex, ey, mx, my, sx, sy, d, e, m, s, sh;
    int emax;
    emax = (1 << EXP_W) - 1;
    sx = x[WORD_W-1]; ex = x[MAN_W +: EXP_W]; mx = x[MAN_W-1:0];
    sy = y[WORD_W-1] ^ sb; ey = y[MAN_W +: EXP_W]; my = y[MAN_W-1:0];
    ov = 1'b0;
    if (ex - ey >= MAN_W) begin
      r = mk(sx[0], ex, mx); lat = 2; return;
    end
    if (ey - ex >= MAN_W) begin
      r = mk(sy[0], ey, my); lat = 2; return;
    end
    if (ex >= ey) begin
      my = my >> (ex - ey); e = ex;
    end else begin
      mx = mx >> (ey - ex); e = ey;
    end
    if (sx == sy) begin m = mx + my; s = sx; end
    else if ((ex >= ey && mx >= my) || (ex < ey && mx > my)) begin m = mx - my; s = sx; end
    else begin m = my - mx; s = sy; end
    if (m == 0) begin r = '0; lat = 2; return; end
    sh = 0;
    forever begin
      if (m >= (1 << MAN_W)) begin
        m = m / 2;
        if (e == emax) ov = 1'b1; else e = e + 1;
      end else if (m < (1 << (MAN_W-1)) && e > 0) begin
        m = m * 2; e = e - 1;
      end else break;
      sh++;
    end
    r = mk(s[0], e, m);
    lat = 3 + sh;
  endtask

  task automatic run_op(input string tag, input logic [WORD_W-1:0] x,
                        input logic [WORD_W-1:0] y, input bit sb, input bit disturb);
    logic [WORD_W-1:0] er;
    int lat;
    bit ov;
    ref_op(x, y, sb, er, lat, ov);
    exp_ovf = exp_ovf | ov;
    @(negedge clk);
    x_in = x; y_in = y; sub = sb; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (disturb) begin
      x_in = mk(1'b1, 3, 16'h9999); y_in = mk(1'b0, 200, 16'hF0F0); sub = ~sb;
    end else start = 1'b0;
    for (int k = 1; k <= lat; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1) start = 1'b0;
      check({tag, " done timing R10"}, done == (k == lat), {24'd0, done}, {24'd0, k == lat});
    end
    check({tag, " result"}, result == er, result, er);
    check({tag, " ovf R9"}, ovf == exp_ovf, {24'd0, ovf}, {24'd0, exp_ovf});
    @(posedge clk);
    @(negedge clk);
    check({tag, " done low after pulse R10"}, !done, {24'd0, done}, '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1 reset result", result == '0, result, '0);
    check("R1 reset done", done == 1'b0, {24'd0, done}, '0);
    check("R1 reset ovf", ovf == 1'b0, {24'd0, ovf}, '0);
    rst_n = 1'b1;
    // R12 word layout used throughout: {sign, exp[7:0], mant[15:0]}
    run_op("R2 R8 equal exp carry", mk(0, 10, 16'h8000), mk(0, 10, 16'h8000), 0, 0);
    run_op("R2 equal exp no shift", mk(1, 40, 16'h9000), mk(1, 40, 16'hA000), 0, 0);
    run_op("R3 x larger gap 3", mk(0, 20, 16'hC000), mk(0, 17, 16'h8000), 0, 0);
    run_op("R3 y larger gap 15", mk(0, 15, 16'hFFFF), mk(0, 30, 16'h8000), 0, 0);
    run_op("R4 y dominates gap 16", mk(0, 5, 16'h8000), mk(0, 21, 16'hC000), 0, 0);
    run_op("R4 R5 x dominates sub", mk(1, 100, 16'hB000), mk(0, 50, 16'h8000), 1, 0);
    run_op("R5 R6 R8 sub same sign", mk(0, 10, 16'hC000), mk(0, 10, 16'h8000), 1, 0);
    run_op("R6 y larger neg", mk(0, 10, 16'h8000), mk(1, 10, 16'hC000), 0, 0);
    run_op("R6 R8 cancel many", mk(0, 60, 16'h8001), mk(1, 60, 16'h8000), 0, 0);
    run_op("R7 exact cancel", mk(0, 33, 16'hD00D), mk(0, 33, 16'hD00D), 1, 0);
    run_op("R11 exp floor", mk(0, 1, 16'hA000), mk(0, 1, 16'h9000), 1, 0);
    run_op("R10 start while busy", mk(0, 20, 16'hC000), mk(1, 18, 16'hF000), 0, 1);
    run_op("R9 exp overflow", mk(0, 255, 16'h8000), mk(0, 255, 16'h8000), 0, 0);
    run_op("R9 sticky after", mk(0, 9, 16'h8000), mk(0, 8, 16'h8000), 0, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule